// File: doc/BRIEF.md
# Powerdown Wake and Reset Sequencer

This block decides when a processor core may leave reset after it was woken from a low-power state by an active-low power-on reset pin. The pin is brought into the reference clock domain through a two-flop synchronizer. The sequencer then counts how many reference cycles the pin stays low. The hold that is needed depends on the clock during powerdown. If the clock was stopped or changed frequency, the oscillator needs time to settle and the PLL needs time to lock, so the hold is long. If the clock ran on unchanged, a short hold of a few cycles is enough.

When the pin is released after a long enough hold, core reset is let go. The restart fetch address is presented with a one-cycle valid strobe, and a boot request goes out if the boot strap asked for one. A release that comes too early keeps the core in reset and raises an error flag until the next attempt. Interrupts that arrive while the core sleeps or is held in reset are kept pending. They are shown to the core only once it runs again, and each stays pending until the core acknowledges it.

Top module: `pwrdn_wake_seq`

## Requirements
- R1: The reset pin passes through two synchronizer flops. Core reset (`core_rst_n`) goes low on the third rising reference edge after the pin is first sampled low.
- R2: If `clk_was_disturbed` is low when the hold begins, the pin must be low for at least STABLE_CYC (default 5) reference edges.
- R3: If `clk_was_disturbed` is high when the hold begins, the pin must be low for at least SETTLE_CYC + PLL_LOCK_CYC (default 2000 + 1000 = 3000) reference edges.
- R4: A release after a long enough hold does three things on the third edge after the pin rises. It sets `core_rst_n` to 1, pulses `restart_vld` for exactly one cycle, and sets `restart_addr` to RESTART_ADDR (default 0x10000).
- R5: `boot_req` pulses together with `restart_vld` only if `boot_strap` was high when the hold began. Otherwise it stays 0.
- R6: A release before the required count keeps `core_rst_n` at 0 and sets `short_err` to 1. Neither `restart_vld` nor `boot_req` pulses.
- R7: `short_err` stays set until the pin is next asserted. It is 0 from the cycle in which the new hold starts.
- R8: Every `irq_in` bit that is high at a clock edge is latched as pending, in any state. `irq_out` shows the pending bits only while `core_rst_n` is 1 and `pd_active` is 0, and shows all zeros otherwise.
- R9: A pending bit clears only when `irq_ack` for that bit is high while the core is running. An acknowledge given while the core is masked has no effect. A new interrupt on the same bit in the same cycle as its acknowledge wins, so the bit stays pending.
- R10: While block reset `rst_n` is low, `core_rst_n` is 1 and every other output is 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Crystal reference clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| por_pin_n | input | 1 | Asynchronous active-low power-on reset pin |
| clk_was_disturbed | input | 1 | High if the clock stopped or changed frequency during powerdown |
| boot_strap | input | 1 | High selects a boot sequence after wake |
| pd_active | input | 1 | Core is in its low-power state |
| irq_in | input | IRQ_W | Interrupt request lines |
| irq_ack | input | IRQ_W | Per-bit interrupt acknowledge from the core |
| core_rst_n | output | 1 | Active-low reset to the core |
| restart_vld | output | 1 | One-cycle strobe when the core leaves reset |
| restart_addr | output | ADDR_W | Restart fetch address |
| boot_req | output | 1 | One-cycle boot request, together with restart_vld |
| short_err | output | 1 | Last release came before the required hold |
| irq_out | output | IRQ_W | Pending interrupts presented to the running core |

## Verification
Holds are tried with both settings of the clock-disturbed flag. Their lengths sit one below, at, and randomly around each threshold, so a wrong limit or an off-by-one in the synchronizer or counter shows up as a release on the wrong side. Random boot strap values check that the boot request follows the strap captured at hold entry. Every short release is followed by a valid hold, which shows that the error clears and that recovery works. A directed interrupt sequence covers the remaining cases: interrupts raised during powerdown, acknowledges given while masked, and acknowledges that collide with a new request. Together these separate masking, clearing and set-priority.

// File: rtl/pws_pkg.sv
// Shared types for the powerdown wake and reset sequencer.
package pws_pkg;

    // Sequencer phase: core running, reset pin being counted, or parked after a short hold.
    typedef enum logic [1:0] {
        PWS_RUN   = 2'd0,
        PWS_HOLD  = 2'd1,
        PWS_SHORT = 2'd2
    } pws_state_e;

endpackage

// File: rtl/pws_sync.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes STAGES >= 2 and a level that stays stable far longer than one clock period.
module pws_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/pws_hold_ctrl.sv
// Counts how long the synchronized reset pin stays low and decides on release.
// It releases the core only when the count meets the hold chosen at entry.
// Assumes por_s_n is already in the clk domain.
module pws_hold_ctrl
    import pws_pkg::*;
#(
    parameter int                SETTLE_CYC   = 2000,
    parameter int                PLL_LOCK_CYC = 1000,
    parameter int                STABLE_CYC   = 5,
    parameter int                ADDR_W       = 24,
    parameter logic [ADDR_W-1:0] RESTART_ADDR = 24'h010000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_s_n,
    input  logic              clk_chg,
    input  logic              boot_sel,
    output logic              core_rst_n,
    output logic              restart_vld,
    output logic [ADDR_W-1:0] restart_addr,
    output logic              boot_req,
    output logic              short_err
);

    localparam int LONG_CYC = SETTLE_CYC + PLL_LOCK_CYC;
    localparam int MAX_CYC  = (LONG_CYC > STABLE_CYC) ? LONG_CYC : STABLE_CYC;
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    pws_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] need_q;
    logic             boot_q;

    // Sequencer: start a hold on pin assertion, saturate the count, judge it on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= PWS_RUN;
            cnt_q        <= '0;
            need_q       <= '0;
            boot_q       <= 1'b0;
            core_rst_n   <= 1'b1;
            restart_vld  <= 1'b0;
            restart_addr <= '0;
            boot_req     <= 1'b0;
            short_err    <= 1'b0;
        end else begin
            restart_vld <= 1'b0;
            boot_req    <= 1'b0;
            case (state_q)
                PWS_HOLD: begin
                    if (!por_s_n) begin
                        if (cnt_q < need_q) cnt_q <= cnt_q + CNT_W'(1);
                    end else if (cnt_q >= need_q) begin
                        state_q      <= PWS_RUN;
                        core_rst_n   <= 1'b1;
                        restart_vld  <= 1'b1;
                        restart_addr <= RESTART_ADDR;
                        boot_req     <= boot_q;
                    end else begin
                        state_q   <= PWS_SHORT;
                        short_err <= 1'b1;
                    end
                end
                default: begin
                    if (!por_s_n) begin
                        state_q    <= PWS_HOLD;
                        cnt_q      <= CNT_W'(1);
                        need_q     <= clk_chg ? CNT_W'(LONG_CYC) : CNT_W'(STABLE_CYC);
                        boot_q     <= boot_sel;
                        core_rst_n <= 1'b0;
                        short_err  <= 1'b0;
                    end
                end
            endcase
        end
    end

    // R2/R3: a release never happens before the required count.
    a_r3_release_count_met: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_n) |-> ($past(cnt_q) >= $past(need_q)));

    // R4: the restart strobe lasts one cycle and marks the reset release.
    a_r4_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
        restart_vld |=> !restart_vld);
    a_r4_vld_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        restart_vld |-> (core_rst_n && !$past(core_rst_n)));

    // R5: a boot request only comes with a restart.
    a_r5_boot_with_vld: assert property (@(posedge clk) disable iff (!rst_n)
        boot_req |-> restart_vld);

    // R6: the error flag means the core is still held.
    a_r6_short_held: assert property (@(posedge clk) disable iff (!rst_n)
        short_err |-> !core_rst_n);

    // R7: a new hold clears the error flag.
    a_r7_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst_n) |-> !short_err);

endmodule

// File: rtl/pws_irq_latch.sv
// Holds interrupt requests pending and presents them only while the core runs.
// Assumes irq_ack comes from the running core and is one cycle per service.
module pws_irq_latch #(
    parameter int IRQ_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [IRQ_W-1:0] irq_in,
    input  logic [IRQ_W-1:0] irq_ack,
    output logic [IRQ_W-1:0] irq_out
);

    logic [IRQ_W-1:0] pend_q;
    logic [IRQ_W-1:0] clr;

    // Acknowledges count only while the core runs.
    assign clr = irq_ack & {IRQ_W{run}};

    // Pending store: a new request has priority over a clear of the same bit.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr) | irq_in;
    end

    assign irq_out = pend_q & {IRQ_W{run}};

    // R9: a masked core cannot drop a pending bit.
    a_r9_masked_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    // R9: an acknowledge without a new request clears that bit.
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (run && |(irq_ack & ~irq_in)) |=> ((pend_q & $past(irq_ack & ~irq_in)) == '0));

    // R8: every request is pending after the edge.
    a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
        |irq_in |=> ((pend_q & $past(irq_in)) == $past(irq_in)));

endmodule

// File: rtl/pwrdn_wake_seq.sv
// Top of the powerdown wake and reset sequencer.
// Synchronizes the reset pin, runs the hold check and keeps interrupts pending
// until the core is out of reset and out of powerdown.
module pwrdn_wake_seq #(
    parameter int                SETTLE_CYC   = 2000,
    parameter int                PLL_LOCK_CYC = 1000,
    parameter int                STABLE_CYC   = 5,
    parameter int                SYNC_STAGES  = 2,
    parameter int                IRQ_W        = 8,
    parameter int                ADDR_W       = 24,
    parameter logic [ADDR_W-1:0] RESTART_ADDR = 24'h010000
) (
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic              por_pin_n,
    input  logic              clk_was_disturbed,
    input  logic              boot_strap,
    input  logic              pd_active,
    input  logic [IRQ_W-1:0]  irq_in,
    input  logic [IRQ_W-1:0]  irq_ack,
    output logic              core_rst_n,
    output logic              restart_vld,
    output logic [ADDR_W-1:0] restart_addr,
    output logic              boot_req,
    output logic              short_err,
    output logic [IRQ_W-1:0]  irq_out
);

    logic por_s_n;
    logic core_run;

    pws_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     (por_pin_n),
        .q     (por_s_n)
    );

    pws_hold_ctrl #(
        .SETTLE_CYC   (SETTLE_CYC),
        .PLL_LOCK_CYC (PLL_LOCK_CYC),
        .STABLE_CYC   (STABLE_CYC),
        .ADDR_W       (ADDR_W),
        .RESTART_ADDR (RESTART_ADDR)
    ) u_hold (
        .clk          (ref_clk),
        .rst_n        (rst_n),
        .por_s_n      (por_s_n),
        .clk_chg      (clk_was_disturbed),
        .boot_sel     (boot_strap),
        .core_rst_n   (core_rst_n),
        .restart_vld  (restart_vld),
        .restart_addr (restart_addr),
        .boot_req     (boot_req),
        .short_err    (short_err)
    );

    // The core services interrupts only when out of reset and awake.
    assign core_run = core_rst_n & ~pd_active;

    pws_irq_latch #(
        .IRQ_W (IRQ_W)
    ) u_irq (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .run     (core_run),
        .irq_in  (irq_in),
        .irq_ack (irq_ack),
        .irq_out (irq_out)
    );

    // R1: core reset follows the synchronized pin and never a raw glitch.
    a_r1_sync_path: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $fell(core_rst_n) |-> !$past(por_s_n));

    // R8: nothing reaches the core while it is in reset.
    a_r8_reset_mask: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !core_rst_n |-> (irq_out == '0));

endmodule

// File: tb/pwrdn_wake_seq_tb_top.sv
module pwrdn_wake_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int IRQ_W      = 8;
    localparam int ADDR_W     = 24;
    localparam int SHORT_NEED = 5;
    localparam int LONG_NEED  = 3000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              por_pin_n;
    logic              clk_was_disturbed;
    logic              boot_strap;
    logic              pd_active;
    logic [IRQ_W-1:0]  irq_in;
    logic [IRQ_W-1:0]  irq_ack;
    logic              core_rst_n;
    logic              restart_vld;
    logic [ADDR_W-1:0] restart_addr;
    logic              boot_req;
    logic              short_err;
    logic [IRQ_W-1:0]  irq_out;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrdn_wake_seq dut_i (
        .ref_clk           (clk),
        .rst_n             (rst_n),
        .por_pin_n         (por_pin_n),
        .clk_was_disturbed (clk_was_disturbed),
        .boot_strap        (boot_strap),
        .pd_active         (pd_active),
        .irq_in            (irq_in),
        .irq_ack           (irq_ack),
        .core_rst_n        (core_rst_n),
        .restart_vld       (restart_vld),
        .restart_addr      (restart_addr),
        .boot_req          (boot_req),
        .short_err         (short_err),
        .irq_out           (irq_out)
    );

    function automatic int need_for(input bit chg);
        return chg ? LONG_NEED : SHORT_NEED;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One wake attempt: hold the pin low for h edges, release it, then check the outcome.
    task automatic wake(input int h, input bit chg, input bit boot);
        bit ok;
        ok = (h >= need_for(chg));
        clk_was_disturbed = chg;
        boot_strap        = boot;
        por_pin_n         = 1'b0;
        edges(h);
        por_pin_n = 1'b1;
        edges(3);
        chk(core_rst_n == ok, chg ? "R3 core_rst_n" : "R2 core_rst_n", core_rst_n, ok);
        chk(restart_vld == ok, "R4 restart_vld", restart_vld, ok);
        chk(boot_req == (ok && boot), "R5 boot_req", boot_req, ok && boot);
        chk(short_err == !ok, "R6 short_err", short_err, !ok);
        if (ok) chk(restart_addr == 24'h010000, "R4 restart_addr", restart_addr, 24'h010000);
        edges(1);
        chk(restart_vld == 1'b0, "R4 vld one cycle", restart_vld, 0);
        chk(boot_req == 1'b0, "R5 boot one cycle", boot_req, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5eed);
        rst_n = 1'b0; por_pin_n = 1'b1; clk_was_disturbed = 1'b0; boot_strap = 1'b0;
        pd_active = 1'b0; irq_in = '0; irq_ack = '0;
        edges(3);
        // R10: reset state
        chk(core_rst_n == 1'b1, "R10 core_rst_n", core_rst_n, 1);
        chk(restart_vld == 1'b0 && boot_req == 1'b0 && short_err == 1'b0, "R10 flags",
            {restart_vld, boot_req, short_err}, 0);
        chk(restart_addr == '0 && irq_out == '0, "R10 data", restart_addr, 0);
        rst_n = 1'b1;
        edges(2);

        // R1: two synchronizer flops, then the sequencer register
        por_pin_n = 1'b0; clk_was_disturbed = 1'b0; boot_strap = 1'b1;
        edges(2);
        chk(core_rst_n == 1'b1, "R1 still out of reset", core_rst_n, 1);
        edges(1);
        chk(core_rst_n == 1'b0, "R1 reset on third edge", core_rst_n, 0);
        edges(5);
        por_pin_n = 1'b1;
        edges(3);
        chk(core_rst_n == 1'b1 && restart_vld == 1'b1 && boot_req == 1'b1, "R2 8-edge hold",
            {core_rst_n, restart_vld, boot_req}, 7);
        edges(2);

        // R2 thresholds
        wake(SHORT_NEED - 1, 1'b0, 1'b1);
        chk(core_rst_n == 1'b0, "R6 still held", core_rst_n, 0);
        // R7: a new hold clears the error
        por_pin_n = 1'b0;
        edges(3);
        chk(short_err == 1'b0, "R7 error cleared", short_err, 0);
        edges(10);
        por_pin_n = 1'b1;
        edges(3);
        chk(core_rst_n == 1'b1, "R7 recovery", core_rst_n, 1);
        edges(2);
        wake(SHORT_NEED, 1'b0, 1'b0);
        // R3 thresholds
        wake(LONG_NEED - 1, 1'b1, 1'b1);
        wake(LONG_NEED, 1'b1, 1'b1);
        // A long hold with the short rule still releases
        wake(LONG_NEED - 1, 1'b0, 1'b0);

        // Random attempts around both thresholds
        for (int i = 0; i < 14; i++) begin
            bit chg;
            bit boot;
            int h;
            chg  = ($urandom % 3) == 0;
            boot = $urandom % 2;
            h    = chg ? (LONG_NEED - 8 + int'($urandom % 16)) : (1 + int'($urandom % 10));
            wake(h, chg, boot);
            edges(1);
        end
        wake(SHORT_NEED + 1, 1'b0, 1'b0);

        // R8/R9: interrupts across powerdown and reset
        pd_active = 1'b1;
        irq_in = 8'h05;
        edges(1);
        irq_in = '0;
        chk(irq_out == '0, "R8 masked in powerdown", irq_out, 0);
        irq_ack = 8'h05;
        edges(1);
        irq_ack = '0;
        wake(SHORT_NEED + 1, 1'b0, 1'b0);
        chk(irq_out == '0, "R8 masked while powerdown after wake", irq_out, 0);
        por_pin_n = 1'b0;
        edges(4);
        pd_active = 1'b0;
        irq_in = 8'h80;
        edges(1);
        irq_in = '0;
        chk(irq_out == '0, "R8 masked in core reset", irq_out, 0);
        por_pin_n = 1'b1;
        edges(4);
        chk(irq_out == 8'h85, "R9 masked ack ignored", irq_out, 8'h85);
        irq_ack = 8'h01;
        edges(1);
        irq_ack = '0;
        chk(irq_out == 8'h84, "R9 ack clears one bit", irq_out, 8'h84);
        irq_ack = 8'h04; irq_in = 8'h04;
        edges(1);
        irq_ack = '0; irq_in = '0;
        chk(irq_out == 8'h84, "R9 new request wins", irq_out, 8'h84);
        irq_ack = 8'h84;
        edges(1);
        irq_ack = '0;
        chk(irq_out == '0, "R9 all cleared", irq_out, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule